// File: doc/BRIEF.md
# Scanline HDMA Channel Sequencer

This block is one horizontal-blank DMA channel of a retro video console. At the start of a frame it reads a small header from a table in memory. On every scanline after that it copies 1, 2 or 4 bytes from memory to a group of neighbouring video-register ports. A byte in the table gives the line count. Its top bit selects whether the copy repeats on every line or happens only once. A zero byte ends the table for the frame.

The channel can fetch payload bytes straight from the table (direct) or through a 16-bit pointer taken from the table (indirect). A private "transfer pending" flag decides whether a line copies anything. Only the sequencer changes this flag. CPU writes to the table pointer, the line byte or the enable bit never touch it. So the channel can be started or paused partway through a frame, and it behaves in a predictable way.

Memory is a synchronous read port. A read is issued in one cycle and its data arrives in the next. The sequencer does exactly one memory read or one port write per clock, and it marks the end of each frame-start or line job with a one-cycle done pulse.

Top module: `hdma_channel`

## Requirements
- R1: After reset, `busy`, `done`, `mem_rd` and `port_wr` are low. The channel is inactive and the transfer flag is clear, so a `line_run` before the first `frame_init` reads nothing, writes nothing and pulses `done` in the next cycle.
- R2: The transfer mode selects the byte count and the port offsets, in this order. Mode 0: 1 byte {0}. Mode 1: 2 bytes {0,1}. Mode 2: 2 bytes {0,0}. Modes 3 and 7: 4 bytes {0,0,1,1}. Mode 4: 4 bytes {0,1,2,3}. Mode 5: 4 bytes {0,1,0,1}. Mode 6 is undefined and moves 1 byte to offset 0. Each write goes to `port_base` plus the offset.
- R3: A line with the transfer flag set reads its payload bytes from the table pointer when `use_indirect`=0, or from the indirect pointer when `use_indirect`=1. The pointer used advances by one after each byte.
- R4: The payload copy finishes before the line byte is decremented. The decrement is a full 8-bit decrement, so 0x00 becomes 0xFF, and with repeat bit 1 the next line then transfers.
- R5: If the low 7 bits of the decremented line byte are nonzero, the transfer flag takes bit 7 of the decremented value, so 0x83 transfers on three lines in a row.
- R6: If the low 7 bits reach zero, the next table byte is read into the line byte. In indirect mode two more table bytes follow as the new indirect pointer, low byte first. A nonzero new line byte sets the transfer flag.
- R7: A new line byte of 0x00 stops the channel for the rest of the frame and clears the transfer flag. In indirect mode it is followed by exactly one more table read, which becomes the pointer's high byte, with a low byte of zero. Later line runs in that frame do nothing. `enable` is not changed.
- R8: `frame_init` with `enable`=1 loads the line byte, plus the indirect pointer in indirect mode, and sets the transfer flag. With `enable`=0 it reads nothing and leaves the flag clear. Enabling afterwards therefore starts with a line that does not transfer.
- R9: CPU writes to the table pointer, the line byte or `enable` never change the transfer flag. Writing 0x00 to the line byte only makes the next decrement wrap.
- R10: A `line_run` while `enable`=0 performs no read or write and leaves all channel state unchanged.
- R11: A `line_run` that arrives while `busy` is high is ignored. `mem_rd` and `port_wr` are never high together, and `done` is a single-cycle pulse for each accepted job.
- R12: Each payload byte takes two cycles: the read issue, then `port_wr` in the cycle the data returns. The decrement takes one cycle, and each table read takes two. `done` is high in the cycle after the last step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_init | input | 1 | Start-of-frame strobe |
| line_run | input | 1 | Per-scanline strobe |
| enable | input | 1 | Channel enable |
| xfer_mode | input | 3 | Transfer mode (see R2) |
| use_indirect | input | 1 | 1 = payload through the indirect pointer |
| port_base | input | PORT_W | First port of the target group |
| tbl_wr | input | 1 | CPU write strobe for the table pointer |
| tbl_wdata | input | 16 | New table pointer |
| line_wr | input | 1 | CPU write strobe for the line byte |
| line_wdata | input | 8 | New line byte |
| ind_wr | input | 1 | CPU write strobe for the indirect pointer |
| ind_wdata | input | 16 | New indirect pointer |
| mem_rd | output | 1 | Memory read request |
| mem_addr | output | 16 | Memory read address |
| mem_rdata | input | 8 | Read data, valid the cycle after `mem_rd` |
| port_wr | output | 1 | Port write strobe |
| port_addr | output | PORT_W | Port address |
| port_data | output | 8 | Port write data |
| busy | output | 1 | A job is in progress |
| done | output | 1 | One-cycle end-of-job pulse |

## Verification
The result of every job is due a fixed number of cycles after the strobe. For a line job that copies n bytes and then decrements the line byte, `done` is due 2n+2 cycles after the strobe edge. Each table read adds 2 cycles, so a direct reload adds 2, an indirect reload adds 6, and an indirect terminator adds 4. An ignored or disabled job finishes in 1 cycle. The bench counts falling edges from the strobe up to `done` and compares that count with this arithmetic. On the same falling edges it logs every port write and every memory read address, and compares the logs in order with the sequences that the table contents and R2 predict.

// File: rtl/hdma_pkg.sv
package hdma_pkg;
  localparam int PTR_W  = 16;
  localparam int BYTE_W = 8;
  localparam int OFF_W  = 2;

  typedef enum logic [2:0] {
    S_IDLE,
    S_XRD,
    S_XWR,
    S_DEC,
    S_LRD,
    S_LCAP,
    S_IRD,
    S_ICAP
  } hst_t;
endpackage

// File: rtl/hdma_mode_map.sv
module hdma_mode_map
  import hdma_pkg::*;
(
  input  logic [2:0]       mode,
  input  logic [1:0]       idx,
  output logic [2:0]       nbytes,
  output logic [OFF_W-1:0] off
);
  always_comb begin
    nbytes = 3'd1;
    off    = '0;
    case (mode)
      3'd1: begin nbytes = 3'd2; off = {1'b0, idx[0]}; end
      3'd2: begin nbytes = 3'd2; off = '0; end
      3'd3,
      3'd7: begin nbytes = 3'd4; off = {1'b0, idx[1]}; end
      3'd4: begin nbytes = 3'd4; off = idx; end
      3'd5: begin nbytes = 3'd4; off = {1'b0, idx[0]}; end
      default: begin nbytes = 3'd1; off = '0; end
    endcase
  end
endmodule

// File: rtl/hdma_line_step.sv
module hdma_line_step
  import hdma_pkg::*;
(
  input  logic [BYTE_W-1:0] cur,
  output logic [BYTE_W-1:0] nxt,
  output logic              reload,
  output logic              rep
);
  always_comb begin
    nxt    = cur - 1'b1;
    reload = (nxt[BYTE_W-2:0] == '0);
    rep    = nxt[BYTE_W-1];
  end
endmodule

// File: rtl/hdma_channel.sv
module hdma_channel
  import hdma_pkg::*;
#(
  parameter int PORT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_init,
  input  logic              line_run,
  input  logic              enable,
  input  logic [2:0]        xfer_mode,
  input  logic              use_indirect,
  input  logic [PORT_W-1:0] port_base,
  input  logic              tbl_wr,
  input  logic [PTR_W-1:0]  tbl_wdata,
  input  logic              line_wr,
  input  logic [BYTE_W-1:0] line_wdata,
  input  logic              ind_wr,
  input  logic [PTR_W-1:0]  ind_wdata,
  output logic              mem_rd,
  output logic [PTR_W-1:0]  mem_addr,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic              port_wr,
  output logic [PORT_W-1:0] port_addr,
  output logic [BYTE_W-1:0] port_data,
  output logic              busy,
  output logic              done
);
  hst_t              state;
  logic [PTR_W-1:0]  tbl_ptr;
  logic [PTR_W-1:0]  ind_ptr;
  logic [BYTE_W-1:0] line_q;
  logic              dotx_q;
  logic              active_q;
  logic [1:0]        idx_q;
  logic              ind_hi_q;
  logic              zero_q;
  logic              done_q;

  logic [2:0]        nbytes;
  logic [OFF_W-1:0]  off;
  logic [BYTE_W-1:0] line_nxt;
  logic              line_reload;
  logic              line_rep;

  hdma_mode_map u_map (
    .mode   (xfer_mode),
    .idx    (idx_q),
    .nbytes (nbytes),
    .off    (off)
  );

  hdma_line_step u_step (
    .cur    (line_q),
    .nxt    (line_nxt),
    .reload (line_reload),
    .rep    (line_rep)
  );

  wire payload_from_ind = use_indirect;
  wire last_byte        = ({1'b0, idx_q} == (nbytes - 3'd1));

  always_comb begin
    mem_rd    = (state == S_XRD) || (state == S_LRD) || (state == S_IRD);
    mem_addr  = (state == S_XRD && payload_from_ind) ? ind_ptr : tbl_ptr;
    port_wr   = (state == S_XWR);
    port_addr = port_base + PORT_W'(off);
    port_data = mem_rdata;
    busy      = (state != S_IDLE);
    done      = done_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      tbl_ptr  <= '0;
      ind_ptr  <= '0;
      line_q   <= '0;
      dotx_q   <= 1'b0;
      active_q <= 1'b0;
      idx_q    <= '0;
      ind_hi_q <= 1'b0;
      zero_q   <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      // CPU writes first; the sequencer below wins on a collision
      if (tbl_wr)  tbl_ptr <= tbl_wdata;
      if (line_wr) line_q  <= line_wdata;
      if (ind_wr)  ind_ptr <= ind_wdata;

      case (state)
        S_IDLE: begin
          if (frame_init) begin
            active_q <= 1'b1;
            dotx_q   <= 1'b0;
            if (enable) state  <= S_LRD;
            else        done_q <= 1'b1;
          end else if (line_run) begin
            if (enable && active_q) begin
              idx_q <= '0;
              state <= dotx_q ? S_XRD : S_DEC;
            end else begin
              done_q <= 1'b1;
            end
          end
        end
        S_XRD: begin
          if (payload_from_ind) ind_ptr <= ind_ptr + 1'b1;
          else                  tbl_ptr <= tbl_ptr + 1'b1;
          state <= S_XWR;
        end
        S_XWR: begin
          if (last_byte) state <= S_DEC;
          else begin
            idx_q <= idx_q + 1'b1;
            state <= S_XRD;
          end
        end
        S_DEC: begin
          line_q <= line_nxt;
          if (line_reload) state <= S_LRD;
          else begin
            dotx_q <= line_rep;
            done_q <= 1'b1;
            state  <= S_IDLE;
          end
        end
        S_LRD: begin
          tbl_ptr <= tbl_ptr + 1'b1;
          state   <= S_LCAP;
        end
        S_LCAP: begin
          line_q   <= mem_rdata;
          zero_q   <= (mem_rdata == '0);
          ind_hi_q <= 1'b0;
          if (use_indirect) state <= S_IRD;
          else begin
            active_q <= (mem_rdata != '0);
            dotx_q   <= (mem_rdata != '0);
            done_q   <= 1'b1;
            state    <= S_IDLE;
          end
        end
        S_IRD: begin
          tbl_ptr <= tbl_ptr + 1'b1;
          state   <= S_ICAP;
        end
        S_ICAP: begin
          if (zero_q) begin
            ind_ptr  <= {mem_rdata, 8'h00};
            active_q <= 1'b0;
            dotx_q   <= 1'b0;
            done_q   <= 1'b1;
            state    <= S_IDLE;
          end else if (!ind_hi_q) begin
            ind_ptr[7:0] <= mem_rdata;
            ind_hi_q     <= 1'b1;
            state        <= S_IRD;
          end else begin
            ind_ptr[15:8] <= mem_rdata;
            dotx_q        <= 1'b1;
            done_q        <= 1'b1;
            state         <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hdma_channel_chk.sv
module hdma_channel_chk #(
  parameter int PORT_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              frame_init,
  input logic              line_run,
  input logic              enable,
  input logic              busy,
  input logic              done,
  input logic              mem_rd,
  input logic              port_wr,
  input logic [PORT_W-1:0] port_addr,
  input logic [PORT_W-1:0] port_base,
  input logic              dotx
);
  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!busy && !done && !mem_rd && !port_wr));

  // R11
  one_op_chk: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && port_wr));

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R2
  port_range_chk: assert property (@(posedge clk) disable iff (rst)
    port_wr |-> (PORT_W'(port_addr - port_base) < PORT_W'(4)));

  // R12
  write_in_job_chk: assert property (@(posedge clk) disable iff (rst)
    port_wr |-> busy);

  // R9
  flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !frame_init && !line_run) |=> $stable(dotx));

  // R10
  disabled_run_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && line_run && !frame_init && !enable) |=> (!busy && $stable(dotx)));
endmodule

bind hdma_channel hdma_channel_chk #(.PORT_W(PORT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .frame_init (frame_init),
  .line_run   (line_run),
  .enable     (enable),
  .busy       (busy),
  .done       (done),
  .mem_rd     (mem_rd),
  .port_wr    (port_wr),
  .port_addr  (port_addr),
  .port_base  (port_base),
  .dotx       (dotx_q)
);

// File: tb/hdma_channel_test.sv
module hdma_channel_test;
  localparam int TCLK = 10;
  localparam logic [7:0] BASE = 8'h21;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frame_init = 0, line_run = 0, enable = 0, use_indirect = 0;
  logic [2:0] xfer_mode = 0;
  logic tbl_wr = 0, line_wr = 0, ind_wr = 0;
  logic [15:0] tbl_wdata = 0, ind_wdata = 0;
  logic [7:0] line_wdata = 0;
  logic mem_rd, port_wr, busy, done;
  logic [15:0] mem_addr;
  logic [7:0] mem_rdata, port_addr, port_data;

  always #(TCLK/2) clk = ~clk;

  hdma_channel uut (
    .clk(clk), .rst(rst), .frame_init(frame_init), .line_run(line_run),
    .enable(enable), .xfer_mode(xfer_mode), .use_indirect(use_indirect),
    .port_base(BASE), .tbl_wr(tbl_wr), .tbl_wdata(tbl_wdata),
    .line_wr(line_wr), .line_wdata(line_wdata), .ind_wr(ind_wr),
    .ind_wdata(ind_wdata), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .port_wr(port_wr), .port_addr(port_addr),
    .port_data(port_data), .busy(busy), .done(done)
  );

  logic [7:0] mem [256];
  always @(posedge clk) if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];

  int checks = 0, fails = 0;
  int wcnt = 0, rcnt = 0, dcnt = 0, k = 0;
  logic [7:0]  wa [16];
  logic [7:0]  wd [16];
  logic [15:0] ra [16];

  always @(negedge clk) begin
    if (port_wr && wcnt < 16) begin wa[wcnt] = port_addr; wd[wcnt] = port_data; wcnt++; end
    if (mem_rd && rcnt < 16) begin ra[rcnt] = mem_addr; rcnt++; end
    if (done) dcnt++;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  task automatic op(input bit init, input int exp_k, input int extra, input string tag);
    @(negedge clk);
    wcnt = 0; rcnt = 0; dcnt = 0;
    if (init) frame_init = 1; else line_run = 1;
    @(negedge clk);
    frame_init = 0; line_run = 0; k = 1;
    while (!done && k < 100) begin
      @(negedge clk);
      k++;
      line_run = (k == extra);
    end
    line_run = 0;
    chk(k == exp_k, {tag, " R12 cycles to done"}, k, exp_k);
    repeat (3) @(negedge clk);
    chk(dcnt == 1, {tag, " R11 single done"}, dcnt, 1);
  endtask

  task automatic exp_w(input int i, input int off, input logic [7:0] d, input string tag);
    chk(wa[i] == BASE + 8'(off), {tag, " R2 port address"}, int'(wa[i]), int'(BASE) + off);
    chk(wd[i] == d, {tag, " R3 port data"}, int'(wd[i]), int'(d));
  endtask

  task automatic exp_r(input int i, input logic [15:0] a, input string tag);
    chk(ra[i] == a, {tag, " R3 read address"}, int'(ra[i]), int'(a));
  endtask

  task automatic counts(input int w, input int r, input string tag);
    chk(wcnt == w, {tag, " write count"}, wcnt, w);
    chk(rcnt == r, {tag, " read count"}, rcnt, r);
  endtask

  task automatic cpu_tbl(input logic [15:0] v);
    @(negedge clk); tbl_wr = 1; tbl_wdata = v; @(negedge clk); tbl_wr = 0;
  endtask
  task automatic cpu_line(input logic [7:0] v);
    @(negedge clk); line_wr = 1; line_wdata = v; @(negedge clk); line_wr = 0;
  endtask

  function automatic int n_of(input int m);
    case (m) 1, 2: return 2; 3, 4, 5, 7: return 4; default: return 1; endcase
  endfunction
  function automatic int off_of(input int m, input int i);
    case (m)
      1, 5:    return i % 2;
      3, 7:    return i / 2;
      4:       return i;
      default: return 0;
    endcase
  endfunction

  task automatic t_reset();
    chk(!busy && !done && !port_wr && !mem_rd, "R1 outputs after reset",
        {busy, done, port_wr, mem_rd}, 0);
    op(0, 1, 0, "R1 run before init");
    counts(0, 0, "R1 run before init");
  endtask

  task automatic t_direct_mode3();
    mem[8'h10] = 8'h02;
    for (int i = 0; i < 4; i++) mem[8'h11 + i] = 8'hA0 + 8'(i);
    mem[8'h15] = 8'h81;
    for (int i = 0; i < 4; i++) mem[8'h16 + i] = 8'hB0 + 8'(i);
    mem[8'h1A] = 8'h00;
    xfer_mode = 3; use_indirect = 0; enable = 1;
    cpu_tbl(16'h0010);
    op(1, 3, 0, "R8 init direct");
    counts(0, 1, "R8 init direct"); exp_r(0, 16'h0010, "R8 init direct");
    op(0, 10, 3, "R11 run with extra strobe");
    counts(4, 4, "R2 mode3 line1");
    for (int i = 0; i < 4; i++) exp_w(i, i / 2, 8'hA0 + 8'(i), "R2 mode3 line1");
    op(0, 4, 0, "R5 no-repeat line");
    counts(0, 1, "R5 no-repeat line"); exp_r(0, 16'h0015, "R6 reload read");
    op(0, 12, 0, "R6 repeat-set line");
    counts(4, 5, "R6 repeat-set line");
    for (int i = 0; i < 4; i++) exp_w(i, i / 2, 8'hB0 + 8'(i), "R6 repeat-set line");
    exp_r(4, 16'h001A, "R7 terminator read");
    op(0, 1, 0, "R7 after terminator");
    counts(0, 0, "R7 after terminator");
  endtask

  task automatic t_repeat();
    mem[8'h30] = 8'h83; mem[8'h31] = 8'hC1; mem[8'h32] = 8'hC2;
    mem[8'h33] = 8'hC3; mem[8'h34] = 8'h00;
    xfer_mode = 0; cpu_tbl(16'h0030);
    op(1, 3, 0, "R7 restart next frame");
    op(0, 4, 0, "R5 repeat line1"); counts(1, 1, "R5 repeat line1");
    exp_w(0, 0, 8'hC1, "R5 repeat line1");
    op(0, 4, 0, "R5 repeat line2"); counts(1, 1, "R5 repeat line2");
    exp_w(0, 0, 8'hC2, "R5 repeat line2");
    op(0, 6, 0, "R5 repeat line3"); counts(1, 2, "R5 repeat line3");
    exp_w(0, 0, 8'hC3, "R5 repeat line3");
    op(0, 1, 0, "R7 stopped"); counts(0, 0, "R7 stopped");
  endtask

  task automatic t_indirect();
    mem[8'h40] = 8'h01; mem[8'h41] = 8'h80; mem[8'h42] = 8'h00;
    mem[8'h43] = 8'h00; mem[8'h44] = 8'h12; mem[8'h45] = 8'h55;
    mem[8'h80] = 8'hD0; mem[8'h81] = 8'hD1;
    xfer_mode = 1; use_indirect = 1; cpu_tbl(16'h0040);
    op(1, 7, 0, "R6 indirect init");
    counts(0, 3, "R6 indirect init"); exp_r(2, 16'h0042, "R6 indirect init");
    op(0, 10, 0, "R7 indirect terminator");
    counts(2, 4, "R7 indirect terminator");
    exp_w(0, 0, 8'hD0, "R3 indirect payload");
    exp_w(1, 1, 8'hD1, "R3 indirect payload");
    exp_r(0, 16'h0080, "R3 indirect pointer");
    exp_r(1, 16'h0081, "R3 indirect pointer");
    exp_r(3, 16'h0044, "R7 one extra read");
    op(0, 1, 0, "R7 indirect stopped"); counts(0, 0, "R7 indirect stopped");
    use_indirect = 0;
  endtask

  task automatic t_midframe();
    mem[8'h50] = 8'hE1; mem[8'h51] = 8'hE2; mem[8'h52] = 8'hE3;
    xfer_mode = 0; enable = 0;
    op(1, 1, 0, "R8 init while disabled"); counts(0, 0, "R8 init while disabled");
    cpu_tbl(16'h0050); cpu_line(8'h00); enable = 1;
    op(0, 2, 0, "R8 first enabled line"); counts(0, 0, "R8 first enabled line");
    op(0, 4, 0, "R4 wrap to 0xFF"); counts(1, 1, "R4 wrap to 0xFF");
    exp_w(0, 0, 8'hE1, "R4 wrap to 0xFF");
    enable = 0;
    op(0, 1, 0, "R10 disabled line"); counts(0, 0, "R10 disabled line");
    enable = 1;
    op(0, 4, 0, "R10 state kept"); counts(1, 1, "R10 state kept");
    exp_w(0, 0, 8'hE2, "R10 state kept");
    cpu_line(8'h00);
    op(0, 4, 0, "R9 line write keeps flag"); counts(1, 1, "R9 line write keeps flag");
    exp_w(0, 0, 8'hE3, "R9 line write keeps flag");
  endtask

  task automatic t_modes();
    mem[8'h60] = 8'h01;
    for (int i = 0; i < 4; i++) mem[8'h61 + i] = 8'hF0 + 8'(i);
    mem[8'h65] = 8'h00;
    for (int m = 0; m < 8; m++) begin
      xfer_mode = 3'(m); cpu_tbl(16'h0060);
      op(1, 3, 0, "R2 mode init");
      op(0, 2 * n_of(m) + 4, 0, $sformatf("R2 mode %0d", m));
      counts(n_of(m), n_of(m) + 1, $sformatf("R2 mode %0d", m));
      for (int i = 0; i < n_of(m); i++)
        exp_w(i, off_of(m, i), 8'hF0 + 8'(i), $sformatf("R2 mode %0d", m));
    end
  endtask

  initial begin
    #(TCLK * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_direct_mode3();
    t_repeat();
    t_indirect();
    t_midframe();
    t_modes();
    summary();
    $finish;
  end
endmodule